// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Priority Selector

This block looks at every interrupt source of a small controller and, for each CPU it serves, works out which pending interrupt that CPU should see next. It reads per-CPU enable and pending bits, a per-source CPU target mask and 8-bit priorities. Sources 0 to 31 are private: each CPU has its own copy of their priority. Sources from 32 up are shared and have one priority for all CPUs. A global enable, a per-CPU enable, a per-CPU priority mask and a per-CPU running priority (9 bits, so that 0x100 can mean idle) decide what gets through.

For each CPU the block publishes a 10-bit highest-pending ID and drives a request line. Both are registered and follow any input change one clock later. Register access, acknowledge and end-of-interrupt handling, and edge/level detection on the source lines are all done outside this block.

Top module: `psel_top`

## Requirements
- R1: Among eligible sources for a CPU, the one with the numerically lowest priority value is selected.
- R2: When several eligible sources share the lowest priority value, the lowest source ID is selected.
- R3: When a CPU has no eligible source, or nothing is published for it, its ID output reads 1023 (0x3FF).
- R4: A source is eligible for CPU c only when both its enable bit and its pending bit for c are set. Bit index is c*NUM_SRC+id.
- R5: IDs 0..31 ignore the target mask. An ID of 32 or above is eligible for CPU c only if bit id*NUM_CPU+c of the target mask is set.
- R6: The selected ID is published only when its priority is strictly below that CPU's 8-bit priority mask. Otherwise the output is 1023.
- R7: The request line is high only when an ID is published and its priority is also strictly below the CPU's 9-bit running priority. A running priority of 0x100 (idle) is beaten by any 8-bit priority.
- R8: When the global enable or the CPU's own enable is low, that CPU's request is low and its ID is 1023.
- R9: Outputs are registered. After reset they read ID 1023 and request low, and they reflect new inputs one clock edge after the change.
- R10: Private priorities are held per CPU. The private priority of CPU c for ID i sits at bits (c*32+i)*8 +: 8. The shared priority for ID i sits at (i-32)*8 +: 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global distribution enable |
| cpu_en | input | NUM_CPU | Per-CPU interface enable |
| src_en | input | NUM_CPU*NUM_SRC | Enable bit per CPU and source |
| src_pend | input | NUM_CPU*NUM_SRC | Pending bit per CPU and source |
| tgt_mask | input | NUM_SRC*NUM_CPU | CPU target bits per source |
| prv_prio | input | NUM_CPU*256 | Private priorities, per CPU, IDs 0..31 |
| shr_prio | input | (NUM_SRC-32)*8 | Shared priorities, IDs 32 and up |
| pri_mask | input | NUM_CPU*8 | Per-CPU priority mask |
| run_prio | input | NUM_CPU*9 | Per-CPU running priority, 0x100 when idle |
| hp_id | output | NUM_CPU*10 | Registered highest-pending ID per CPU |
| irq_req | output | NUM_CPU | Registered request line per CPU |

## Verification
The bench goes after the strict comparisons. A priority equal to the mask must yield 1023, and a priority equal to the running priority must leave the request low. A design using less-or-equal would publish or raise the request one step too early. Ties are placed between a low private ID and a high shared ID, so a scan that replaced on equal values would report the higher ID. Private sources are given cleared target bits and shared sources are given a cleared bit for one CPU only: a design that applied the target check to every ID, or checked the wrong CPU's bit, would lose or leak interrupts. Random sweeps over sparse pending patterns also catch a swapped private priority bank or a missing enable gate.

// File: rtl/psel_pkg.sv
// Shared constants for the pending interrupt priority selector.
package psel_pkg;
    localparam int ID_W      = 10;
    localparam int PRIO_W    = 8;
    localparam int RUN_W     = PRIO_W + 1;
    localparam int PRIV_CNT  = 32;
    localparam logic [ID_W-1:0]  SPURIOUS_ID = 10'd1023;
    localparam logic [RUN_W-1:0] IDLE_RUN    = 9'h100;
endpackage

// File: rtl/psel_pick.sv
// Finds the best eligible source for one CPU.
// Assumes: prio is already resolved for this CPU (private or shared).
// The scan replaces the best only on a strictly lower priority, so the lowest ID wins ties.
module psel_pick
    import psel_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        tgt,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    output logic                      valid,
    output logic [ID_W-1:0]           best_id,
    output logic [PRIO_W-1:0]         best_prio
);
    logic [NUM_SRC-1:0] cand;

    // eligibility per source: enabled, pending, private or targeted at this CPU
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            cand[s] = en[s] && pend[s] && ((s < PRIV_CNT) || tgt[s]);
        end
    end

    // linear scan for the lowest priority value, first ID kept on ties
    always_comb begin
        valid     = 1'b0;
        best_id   = SPURIOUS_ID;
        best_prio = '1;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (cand[s] && (!valid || (prio[s*PRIO_W +: PRIO_W] < best_prio))) begin
                valid     = 1'b1;
                best_id   = ID_W'(s);
                best_prio = prio[s*PRIO_W +: PRIO_W];
            end
        end
    end

    // R4
    pick_enabled_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (en[best_id] && pend[best_id]));

    // R3
    pick_none_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (!valid && best_id == SPURIOUS_ID));
endmodule

// File: rtl/psel_gate.sv
// Applies the enables, the priority mask and the running priority for one CPU,
// and registers the resulting ID and request.
// Assumes: the inputs come from psel_pick in the same cycle.
module psel_gate
    import psel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              cpu_en,
    input  logic              valid,
    input  logic [ID_W-1:0]   best_id,
    input  logic [PRIO_W-1:0] best_prio,
    input  logic [PRIO_W-1:0] mask,
    input  logic [RUN_W-1:0]  run,
    output logic [ID_W-1:0]   id_q,
    output logic              irq_q
);
    logic pub;
    logic req;

    // publish when enabled and strictly under the mask; request when also under running
    always_comb begin
        pub = glb_en && cpu_en && valid && (best_prio < mask);
        req = pub && ({1'b0, best_prio} < run);
    end

    // output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= SPURIOUS_ID;
            irq_q <= 1'b0;
        end else begin
            id_q  <= pub ? best_id : SPURIOUS_ID;
            irq_q <= req;
        end
    end

    // R7
    gate_req_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (id_q != SPURIOUS_ID));

    // R8
    gate_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(glb_en && cpu_en) |=> (!irq_q && id_q == SPURIOUS_ID));

    // R6
    gate_mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (best_prio >= mask) |=> (id_q == SPURIOUS_ID));
endmodule

// File: rtl/psel_top.sv
// Per-CPU pending interrupt priority selector.
// Builds each CPU's priority view (private bank for IDs below 32, shared above),
// picks the best candidate and gates it through mask and running priority.
// Assumes: NUM_SRC is a multiple of 32 and at most 128; NUM_CPU is 1..8.
module psel_top
    import psel_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              glb_en,
    input  logic [NUM_CPU-1:0]                cpu_en,
    input  logic [NUM_CPU*NUM_SRC-1:0]        src_en,
    input  logic [NUM_CPU*NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC*NUM_CPU-1:0]        tgt_mask,
    input  logic [NUM_CPU*PRIV_CNT*PRIO_W-1:0] prv_prio,
    input  logic [(NUM_SRC-PRIV_CNT)*PRIO_W-1:0] shr_prio,
    input  logic [NUM_CPU*PRIO_W-1:0]         pri_mask,
    input  logic [NUM_CPU*RUN_W-1:0]          run_prio,
    output logic [NUM_CPU*ID_W-1:0]           hp_id,
    output logic [NUM_CPU-1:0]                irq_req
);
    localparam int SHR_CNT = NUM_SRC - PRIV_CNT;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_SRC-1:0]        tgt_c;
        logic [NUM_SRC*PRIO_W-1:0] prio_c;
        logic                      valid_c;
        logic [ID_W-1:0]           id_c;
        logic [PRIO_W-1:0]         bp_c;

        // gather this CPU's target bits and priority view
        always_comb begin
            for (int s = 0; s < NUM_SRC; s++) begin
                tgt_c[s] = tgt_mask[s*NUM_CPU + c];
            end
            prio_c[PRIV_CNT*PRIO_W-1:0] = prv_prio[c*PRIV_CNT*PRIO_W +: PRIV_CNT*PRIO_W];
            prio_c[NUM_SRC*PRIO_W-1:PRIV_CNT*PRIO_W] = shr_prio[SHR_CNT*PRIO_W-1:0];
        end

        psel_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (src_en[c*NUM_SRC +: NUM_SRC]),
            .pend     (src_pend[c*NUM_SRC +: NUM_SRC]),
            .tgt      (tgt_c),
            .prio     (prio_c),
            .valid    (valid_c),
            .best_id  (id_c),
            .best_prio(bp_c)
        );

        psel_gate u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .glb_en   (glb_en),
            .cpu_en   (cpu_en[c]),
            .valid    (valid_c),
            .best_id  (id_c),
            .best_prio(bp_c),
            .mask     (pri_mask[c*PRIO_W +: PRIO_W]),
            .run      (run_prio[c*RUN_W +: RUN_W]),
            .id_q     (hp_id[c*ID_W +: ID_W]),
            .irq_q    (irq_req[c])
        );
    end
endmodule

// File: tb/psel_top_bench.sv
module psel_top_bench;
    localparam int NS = 64;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic glb_en;
    logic [NC-1:0] cpu_en;
    logic [NC*NS-1:0] src_en, src_pend;
    logic [NS*NC-1:0] tgt_mask;
    logic [NC*32*8-1:0] prv_prio;
    logic [(NS-32)*8-1:0] shr_prio;
    logic [NC*8-1:0] pri_mask;
    logic [NC*9-1:0] run_prio;
    logic [NC*10-1:0] hp_id;
    logic [NC-1:0] irq_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    psel_top #(.NUM_SRC(NS), .NUM_CPU(NC)) u_psel_top (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cpu_en(cpu_en),
        .src_en(src_en), .src_pend(src_pend), .tgt_mask(tgt_mask),
        .prv_prio(prv_prio), .shr_prio(shr_prio), .pri_mask(pri_mask),
        .run_prio(run_prio), .hp_id(hp_id), .irq_req(irq_req)
    );

    function automatic logic [7:0] prio_of(int c, int s);
        if (s < 32) return prv_prio[(c*32+s)*8 +: 8];
        return shr_prio[(s-32)*8 +: 8];
    endfunction

    // expected outputs derived from the requirements
    task automatic model(input int c, output logic [9:0] id, output logic rq);
        int best = -1;
        int bp = 256;
        id = 10'd1023;
        rq = 1'b0;
        for (int s = 0; s < NS; s++) begin
            if (src_en[c*NS+s] && src_pend[c*NS+s] && (s < 32 || tgt_mask[s*NC+c])) begin
                if (int'(prio_of(c, s)) < bp) begin
                    bp = int'(prio_of(c, s));
                    best = s;
                end
            end
        end
        if (glb_en && cpu_en[c] && best >= 0 && bp < int'(pri_mask[c*8 +: 8])) begin
            id = 10'(best);
            rq = (bp < int'(run_prio[c*9 +: 9]));
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #5;
    endtask

    task automatic check_all(input string req);
        logic [9:0] eid;
        logic erq;
        for (int c = 0; c < NC; c++) begin
            model(c, eid, erq);
            chk(hp_id[c*10 +: 10] == eid, req, int'(hp_id[c*10 +: 10]), int'(eid));
            chk(irq_req[c] == erq, req, int'(irq_req[c]), int'(erq));
        end
    endtask

    task automatic quiet_setup;
        @(negedge clk);
        glb_en = 1'b1; cpu_en = '1;
        src_en = '1; src_pend = '0; tgt_mask = '1;
        prv_prio = '1; shr_prio = '1;
        pri_mask = {NC{8'hFF}}; run_prio = {NC{9'h100}};
    endtask

    initial begin
        #(20*200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        glb_en = 1'b1; cpu_en = '1; src_en = '1; src_pend = '1; tgt_mask = '1;
        prv_prio = '0; shr_prio = '0; pri_mask = '1; run_prio = '1;
        step(); step();
        // R9 reset state, inputs would otherwise select ID 0
        chk(hp_id == {NC{10'd1023}}, "R9 reset id", int'(hp_id[9:0]), 1023);
        chk(irq_req == '0, "R9 reset req", int'(irq_req), 0);
        @(negedge clk); rst_n = 1'b1;

        // R3 nothing pending
        quiet_setup(); step();
        chk(hp_id[9:0] == 10'd1023, "R3 none", int'(hp_id[9:0]), 1023);

        // R1 lower value wins: ID 45 prio 3 vs ID 7 prio 9
        quiet_setup();
        src_pend[0*NS+7] = 1; prv_prio[(0*32+7)*8 +: 8] = 8'd9;
        src_pend[0*NS+45] = 1; shr_prio[(45-32)*8 +: 8] = 8'd3;
        step();
        chk(hp_id[9:0] == 10'd45, "R1 lowest value", int'(hp_id[9:0]), 45);

        // R9 one-cycle update: raise ID 2 to prio 1, then check next edge
        @(negedge clk); src_pend[0*NS+2] = 1; prv_prio[(0*32+2)*8 +: 8] = 8'd1;
        #2;
        chk(hp_id[9:0] == 10'd45, "R9 held before edge", int'(hp_id[9:0]), 45);
        step();
        chk(hp_id[9:0] == 10'd2, "R9 after edge", int'(hp_id[9:0]), 2);

        // R2 tie: ID 5 and ID 40 both prio 4
        quiet_setup();
        src_pend[0*NS+40] = 1; shr_prio[(40-32)*8 +: 8] = 8'd4;
        src_pend[0*NS+5] = 1; prv_prio[(0*32+5)*8 +: 8] = 8'd4;
        step();
        chk(hp_id[9:0] == 10'd5, "R2 tie lowest id", int'(hp_id[9:0]), 5);

        // R4 enable cleared hides a pending source
        @(negedge clk); src_en[0*NS+5] = 0; step();
        chk(hp_id[9:0] == 10'd40, "R4 disabled skipped", int'(hp_id[9:0]), 40);

        // R5 private ignores target mask; shared honours per-CPU target bit
        quiet_setup(); tgt_mask = '0;
        src_pend[1*NS+3] = 1; prv_prio[(1*32+3)*8 +: 8] = 8'd20;
        src_pend[0*NS+50] = 1; src_pend[1*NS+50] = 1; shr_prio[(50-32)*8 +: 8] = 8'd2;
        tgt_mask[50*NC+0] = 1;
        step();
        chk(hp_id[9:0] == 10'd50, "R5 shared targeted cpu0", int'(hp_id[9:0]), 50);
        chk(hp_id[19:10] == 10'd3, "R5 private ignores mask cpu1", int'(hp_id[19:10]), 3);

        // R10 per-CPU private priority: ID 10 vs 11 swapped between CPUs
        quiet_setup();
        src_pend[0*NS+10] = 1; src_pend[0*NS+11] = 1;
        src_pend[1*NS+10] = 1; src_pend[1*NS+11] = 1;
        prv_prio[(0*32+10)*8 +: 8] = 8'd8; prv_prio[(0*32+11)*8 +: 8] = 8'd6;
        prv_prio[(1*32+10)*8 +: 8] = 8'd6; prv_prio[(1*32+11)*8 +: 8] = 8'd8;
        step();
        chk(hp_id[9:0] == 10'd11, "R10 cpu0 bank", int'(hp_id[9:0]), 11);
        chk(hp_id[19:10] == 10'd10, "R10 cpu1 bank", int'(hp_id[19:10]), 10);

        // R6 mask boundary: prio 0x40 with mask 0x40 blocked, 0x41 passes
        quiet_setup();
        src_pend[0*NS+33] = 1; shr_prio[(33-32)*8 +: 8] = 8'h40;
        pri_mask[7:0] = 8'h40; step();
        chk(hp_id[9:0] == 10'd1023, "R6 equal mask blocked", int'(hp_id[9:0]), 1023);
        chk(irq_req[0] == 1'b0, "R6 equal mask no req", int'(irq_req[0]), 0);
        @(negedge clk); pri_mask[7:0] = 8'h41; step();
        chk(hp_id[9:0] == 10'd33, "R6 under mask", int'(hp_id[9:0]), 33);
        chk(irq_req[0] == 1'b1, "R7 idle run beaten", int'(irq_req[0]), 1);

        // R7 running priority boundary
        @(negedge clk); run_prio[8:0] = 9'h040; step();
        chk(irq_req[0] == 1'b0, "R7 equal running no req", int'(irq_req[0]), 0);
        chk(hp_id[9:0] == 10'd33, "R7 id still published", int'(hp_id[9:0]), 33);
        @(negedge clk); run_prio[8:0] = 9'h041; step();
        chk(irq_req[0] == 1'b1, "R7 under running", int'(irq_req[0]), 1);

        // R7 idle running with priority 0xFE
        @(negedge clk); shr_prio[(33-32)*8 +: 8] = 8'hFE; pri_mask[7:0] = 8'hFF;
        run_prio[8:0] = 9'h100; step();
        chk(irq_req[0] == 1'b1, "R7 idle vs 0xFE", int'(irq_req[0]), 1);

        // R8 enables
        @(negedge clk); cpu_en[0] = 0; step();
        chk(hp_id[9:0] == 10'd1023 && irq_req[0] == 0, "R8 cpu disabled", int'(hp_id[9:0]), 1023);
        @(negedge clk); cpu_en[0] = 1; glb_en = 0; step();
        chk(hp_id[9:0] == 10'd1023 && irq_req[0] == 0, "R8 global disabled", int'(hp_id[9:0]), 1023);

        // R1 R2 R4 R5 random sweep with sparse pending
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            glb_en = ($urandom_range(0, 15) != 0);
            cpu_en = NC'($urandom);
            if ($urandom_range(0, 3) != 0) cpu_en = '1;
            for (int w = 0; w < NC*NS; w += 32) begin
                src_en[w +: 32] = $urandom | $urandom;
                src_pend[w +: 32] = $urandom & $urandom & $urandom;
                tgt_mask[w +: 32] = $urandom;
            end
            for (int w = 0; w < NC*32*8; w += 32) prv_prio[w +: 32] = $urandom & 32'h0F0F0F0F;
            for (int w = 0; w < (NS-32)*8; w += 32) shr_prio[w +: 32] = $urandom & 32'h0F0F0F0F;
            for (int c = 0; c < NC; c++) begin
                pri_mask[c*8 +: 8] = 8'($urandom_range(0, 16));
                run_prio[c*9 +: 9] = 9'($urandom_range(0, 20));
                if ($urandom_range(0, 3) == 0) run_prio[c*9 +: 9] = 9'h100;
            end
            step();
            check_all("R1 sweep");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule